// File: doc/BRIEF.md
# Nested Exception Entry and Return Controller

This block sits between a pending-request arbiter and the execution side of a processor. Each cycle it sees the arbiter's most urgent pending request (identifier and priority) and a strobe that marks the end of the running handler. It keeps a stack of the exceptions that are active, and with it the priority the core is running at. From these it decides, once per cycle, whether to start a new handler, preempting any handler that is running, or what to do when a handler ends.

When a handler ends, the block either chains straight into a waiting handler without restoring context (tail-chain) or restores the interrupted context with a stack pop (return). A lower priority value means more urgent. The running priority goes back to the arbiter, so the arbiter can mask requests that cannot preempt. The context save to memory, the vector fetch and the arbitration itself are done elsewhere. The block takes a one-bit input that says the completed handler was serving a late-arriving exception.

Top module: `exc_nest_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `depth_o` is 0, `run_prio_o` is all ones, `act_id_o` is 0, and `enter_o`, `nest_o`, `tail_o`, `ret_o` and `ovf_o` are all 0.
- R2: When no exception is active and `req_valid_i` is high (and `done_i` is low), the request is pushed. One cycle later `enter_o` is 1, `nest_o` is 0, `depth_o` is 1, `run_prio_o` equals the request priority and `act_id_o` equals the request identifier.
- R3: A request whose priority value is strictly lower than `run_prio_o` preempts the running handler. One cycle later `enter_o` and `nest_o` are 1, `depth_o` has gone up by one, and the new entry is on top.
- R4: A request whose priority value is equal to or higher than `run_prio_o` does not enter. No pulse follows and `depth_o`, `run_prio_o` and `act_id_o` do not change.
- R5: When `done_i` is high with at least one exception active, a valid request qualifies if `depth_o` is 1 or if its priority value is strictly lower than the priority of the entry directly below the top. A qualifying request gives `tail_o` one cycle later. The top entry is replaced by the request and `depth_o` does not change.
- R6: When `done_i` and `late_i` are high together with a valid request, the decision is tail-chain whatever the priorities are.
- R7: When `done_i` is high with an exception active and no request qualifies under R5 or R6, `ret_o` pulses one cycle later. The top entry is popped, and `run_prio_o` and `act_id_o` show the new top, or the empty values of R1.
- R8: `done_i` has no effect while `depth_o` is 0. No `tail_o` or `ret_o` follows, and the stack changes only through the entry rule of R2.
- R9: At most one of `enter_o`, `tail_o` and `ret_o` is high in any cycle, and each pulse lasts one cycle per decision. A cycle with `done_i` high and an exception active is decided as a completion only, never as a preemption. `nest_o` is high only together with `enter_o`.
- R10: The stack holds up to `STACK_DEPTH` (default 8) entries. A request that would be pushed onto a full stack is refused: there is no `enter_o` and the stack does not change. `ovf_o` goes high and stays high until reset.
- R11: `run_prio_o` always equals the priority of the top entry, or all ones when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Arbiter has a pending request |
| req_id_i | input | ID_W | Identifier of the pending request |
| req_prio_i | input | PRIO_W | Priority of the pending request, lower is more urgent |
| done_i | input | 1 | Running handler has completed |
| late_i | input | 1 | Completed handler was serving a late-arriving exception |
| enter_o | output | 1 | Start of a new handler, one-cycle pulse |
| nest_o | output | 1 | The entry preempted an active handler |
| tail_o | output | 1 | Tail-chain into the new top handler without a pop |
| ret_o | output | 1 | Return with context pop |
| act_id_o | output | ID_W | Identifier of the running exception, 0 if none |
| run_prio_o | output | PRIO_W | Running priority, all ones if none |
| depth_o | output | $clog2(STACK_DEPTH+1) | Number of active exceptions |
| ovf_o | output | 1 | Sticky push-on-full error |

## Verification
The assertions assume that `done_i` is only meaningful while a handler is active. The block filters it by depth rather than relying on the execution side, so the stimulus raises it on an empty stack on purpose. They also assume that request fields are stable only within the cycle they are sampled and that no request is held back between cycles. The bench therefore redrives every input each cycle and makes no assumption about the arbiter clearing a request after entry. Directed sequences cover equal-priority rejection, tail-chain against the entry below, a late-arrival override and a full stack. A long random phase then mixes completion, late and request inputs against a queue model.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    STK_NONE = 2'd0,
    STK_PUSH = 2'd1,
    STK_REPL = 2'd2,
    STK_POP  = 2'd3
  } stk_op_e;

endpackage

// File: rtl/exc_stack.sv
module exc_stack
  import exc_pkg::*;
#(
  parameter int PRIO_W      = 4,
  parameter int ID_W        = 5,
  parameter int STACK_DEPTH = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  stk_op_e                            op,
  input  logic [PRIO_W-1:0]                  wr_prio,
  input  logic [ID_W-1:0]                    wr_id,
  output logic [$clog2(STACK_DEPTH+1)-1:0]   depth_o,
  output logic [PRIO_W-1:0]                  top_prio_o,
  output logic [ID_W-1:0]                    top_id_o,
  output logic [PRIO_W-1:0]                  below_prio_o
);

  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int AW    = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int EW    = PRIO_W + ID_W;

  logic [EW-1:0]    mem [STACK_DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic [CNT_W-1:0] top_ix;
  logic [CNT_W-1:0] below_ix;
  logic [CNT_W-1:0] wr_ix;
  logic [EW-1:0]    top_e;
  logic [EW-1:0]    below_e;

  assign top_ix   = depth_q - CNT_W'(1);
  assign below_ix = depth_q - CNT_W'(2);
  assign wr_ix    = (op == STK_PUSH) ? depth_q : top_ix;

  // Storage: single write port, no reset, so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (op == STK_PUSH || op == STK_REPL) begin
      mem[wr_ix[AW-1:0]] <= {wr_prio, wr_id};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= '0;
    end else begin
      case (op)
        STK_PUSH: depth_q <= depth_q + CNT_W'(1);
        STK_POP:  depth_q <= depth_q - CNT_W'(1);
        default:  depth_q <= depth_q;
      endcase
    end
  end

  assign top_e   = mem[top_ix[AW-1:0]];
  assign below_e = mem[below_ix[AW-1:0]];

  always_comb begin
    depth_o = depth_q;
    if (depth_q == '0) begin
      top_prio_o = '1;
      top_id_o   = '0;
    end else begin
      top_prio_o = top_e[EW-1:ID_W];
      top_id_o   = top_e[ID_W-1:0];
    end
    if (depth_q < CNT_W'(2)) begin
      below_prio_o = '1;
    end else begin
      below_prio_o = below_e[EW-1:ID_W];
    end
  end

  // R10
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    (op == STK_PUSH) |-> (depth_q < CNT_W'(STACK_DEPTH)));

  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (op == STK_POP || op == STK_REPL) |-> (depth_q != '0));

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    depth_q <= CNT_W'(STACK_DEPTH));

endmodule

// File: rtl/exc_decide.sv
module exc_decide
  import exc_pkg::*;
#(
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 8
) (
  input  logic                             req_valid,
  input  logic [PRIO_W-1:0]                req_prio,
  input  logic                             done,
  input  logic                             late,
  input  logic [$clog2(STACK_DEPTH+1)-1:0] depth,
  input  logic [PRIO_W-1:0]                top_prio,
  input  logic [PRIO_W-1:0]                below_prio,
  output stk_op_e                          op,
  output logic                             enter_n,
  output logic                             nest_n,
  output logic                             tail_n,
  output logic                             ret_n,
  output logic                             ovf_set
);

  localparam int CNT_W = $clog2(STACK_DEPTH + 1);

  logic has_act;
  logic full;
  logic last_one;
  logic chain_ok;
  logic preempt_ok;

  assign has_act    = (depth != '0);
  assign full       = (depth == CNT_W'(STACK_DEPTH));
  assign last_one   = (depth == CNT_W'(1));
  assign chain_ok   = req_valid && (late || last_one || (req_prio < below_prio));
  assign preempt_ok = req_valid && (!has_act || (req_prio < top_prio));

  always_comb begin
    op      = STK_NONE;
    enter_n = 1'b0;
    nest_n  = 1'b0;
    tail_n  = 1'b0;
    ret_n   = 1'b0;
    ovf_set = 1'b0;
    if (done && has_act) begin
      if (chain_ok) begin
        op     = STK_REPL;
        tail_n = 1'b1;
      end else begin
        op    = STK_POP;
        ret_n = 1'b1;
      end
    end else if (preempt_ok) begin
      if (full) begin
        ovf_set = 1'b1;
      end else begin
        op      = STK_PUSH;
        enter_n = 1'b1;
        nest_n  = has_act;
      end
    end
  end

endmodule

// File: rtl/exc_nest_ctrl.sv
module exc_nest_ctrl
  import exc_pkg::*;
#(
  parameter int PRIO_W      = 4,
  parameter int ID_W        = 5,
  parameter int STACK_DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid_i,
  input  logic [ID_W-1:0]                  req_id_i,
  input  logic [PRIO_W-1:0]                req_prio_i,
  input  logic                             done_i,
  input  logic                             late_i,
  output logic                             enter_o,
  output logic                             nest_o,
  output logic                             tail_o,
  output logic                             ret_o,
  output logic [ID_W-1:0]                  act_id_o,
  output logic [PRIO_W-1:0]                run_prio_o,
  output logic [$clog2(STACK_DEPTH+1)-1:0] depth_o,
  output logic                             ovf_o
);

  localparam int CNT_W = $clog2(STACK_DEPTH + 1);

  stk_op_e          op;
  logic             enter_n, nest_n, tail_n, ret_n, ovf_set;
  logic [CNT_W-1:0] depth;
  logic [PRIO_W-1:0] top_prio, below_prio;
  logic [ID_W-1:0]  top_id;

  exc_stack #(
    .PRIO_W(PRIO_W), .ID_W(ID_W), .STACK_DEPTH(STACK_DEPTH)
  ) stack_i (
    .clk(clk), .rst(rst), .op(op),
    .wr_prio(req_prio_i), .wr_id(req_id_i),
    .depth_o(depth), .top_prio_o(top_prio), .top_id_o(top_id),
    .below_prio_o(below_prio)
  );

  exc_decide #(
    .PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH)
  ) decide_i (
    .req_valid(req_valid_i), .req_prio(req_prio_i),
    .done(done_i), .late(late_i),
    .depth(depth), .top_prio(top_prio), .below_prio(below_prio),
    .op(op), .enter_n(enter_n), .nest_n(nest_n),
    .tail_n(tail_n), .ret_n(ret_n), .ovf_set(ovf_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enter_o <= 1'b0;
      nest_o  <= 1'b0;
      tail_o  <= 1'b0;
      ret_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      enter_o <= enter_n;
      nest_o  <= nest_n;
      tail_o  <= tail_n;
      ret_o   <= ret_n;
      ovf_o   <= ovf_o | ovf_set;
    end
  end

  assign run_prio_o = top_prio;
  assign act_id_o   = top_id;
  assign depth_o    = depth;

  // R9
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({enter_o, tail_o, ret_o}));

  // R9
  nest_with_enter_chk: assert property (@(posedge clk) disable iff (rst)
    nest_o |-> enter_o);

  // R2
  enter_push_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(enter_o) |-> (depth_o == $past(depth_o) + CNT_W'(1)));

  // R3
  nest_urgent_chk: assert property (@(posedge clk) disable iff (rst)
    (enter_o && nest_o && !$past(rst)) |-> (run_prio_o < $past(run_prio_o)));

  // R5
  tail_keep_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (tail_o && !$past(rst)) |-> $stable(depth_o));

  // R7
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_o && !$past(rst)) |-> (depth_o == $past(depth_o) - CNT_W'(1)));

  // R8
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && depth_o == '0) |=> (!tail_o && !ret_o));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

endmodule

// File: tb/exc_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_nest_ctrl_tb_top;

  localparam int PRIO_W = 4;
  localparam int ID_W   = 5;
  localparam int SD     = 8;
  localparam int CW     = $clog2(SD + 1);
  localparam int IDLE_P = (1 << PRIO_W) - 1;

  logic clk = 1'b0;
  logic rst;
  logic req_valid_i, done_i, late_i;
  logic [ID_W-1:0] req_id_i;
  logic [PRIO_W-1:0] req_prio_i;
  logic enter_o, nest_o, tail_o, ret_o, ovf_o;
  logic [ID_W-1:0] act_id_o;
  logic [PRIO_W-1:0] run_prio_o;
  logic [CW-1:0] depth_o;

  int checks = 0;
  int errors = 0;
  int m_prio[$];
  int m_id[$];
  bit m_ovf = 0;

  always #5 clk = ~clk;

  exc_nest_ctrl #(.PRIO_W(PRIO_W), .ID_W(ID_W), .STACK_DEPTH(SD)) dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_id_i(req_id_i),
    .req_prio_i(req_prio_i), .done_i(done_i), .late_i(late_i),
    .enter_o(enter_o), .nest_o(nest_o), .tail_o(tail_o), .ret_o(ret_o),
    .act_id_o(act_id_o), .run_prio_o(run_prio_o), .depth_o(depth_o),
    .ovf_o(ovf_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, bit e_en, bit e_ns, bit e_tl, bit e_rt);
    int sz = m_prio.size();
    chk(tag, "enter_o", int'(enter_o), int'(e_en));
    chk(tag, "nest_o", int'(nest_o), int'(e_ns));
    chk(tag, "tail_o", int'(tail_o), int'(e_tl));
    chk(tag, "ret_o", int'(ret_o), int'(e_rt));
    chk(tag, "depth_o", int'(depth_o), sz);
    chk("R11", "run_prio_o", int'(run_prio_o), (sz > 0) ? m_prio[sz-1] : IDLE_P);
    chk(tag, "act_id_o", int'(act_id_o), (sz > 0) ? m_id[sz-1] : 0);
    chk("R10", "ovf_o", int'(ovf_o), int'(m_ovf));
  endtask

  // One clock: drive, advance the model, sample 1 ns after the edge
  task automatic step(bit v, int id, int pr, bit dn, bit lt, string tag);
    bit e_en = 0, e_ns = 0, e_tl = 0, e_rt = 0;
    int sz = m_prio.size();
    req_valid_i = v;
    req_id_i    = ID_W'(id);
    req_prio_i  = PRIO_W'(pr);
    done_i      = dn;
    late_i      = lt;
    if (dn && sz > 0) begin
      if (v && (lt || sz == 1 || pr < m_prio[sz-2])) begin
        m_prio[sz-1] = pr;
        m_id[sz-1]   = id;
        e_tl = 1;
      end else begin
        void'(m_prio.pop_back());
        void'(m_id.pop_back());
        e_rt = 1;
      end
    end else if (v && (sz == 0 || pr < m_prio[sz-1])) begin
      if (sz == SD) begin
        m_ovf = 1;
      end else begin
        e_en = 1;
        e_ns = (sz > 0);
        m_prio.push_back(pr);
        m_id.push_back(id);
      end
    end
    @(posedge clk);
    #1;
    chk_all(tag, e_en, e_ns, e_tl, e_rt);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    req_valid_i = 0; req_id_i = '0; req_prio_i = '0; done_i = 0; late_i = 0;
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1", 0, 0, 0, 0);
    rst = 1'b0;
    step(0, 0, 0, 0, 0, "R1");

    step(1, 4, 8, 0, 0, "R2");        // enter on empty stack
    step(1, 5, 8, 0, 0, "R4");        // equal priority stays out
    step(1, 6, 9, 0, 0, "R4");        // less urgent stays out
    step(1, 7, 3, 0, 0, "R3");        // preempt, nest
    step(1, 8, 2, 1, 0, "R9");        // done wins over a preemption
    step(1, 9, 3, 0, 0, "R3");
    step(1, 10, 5, 1, 0, "R5");       // 5 < 8 below: tail-chain
    step(0, 0, 0, 1, 0, "R7");        // return to prio 8
    step(1, 11, 8, 1, 0, "R5");       // depth 1: any pending chains
    step(1, 12, 2, 0, 0, "R3");
    step(1, 13, 10, 1, 1, "R6");      // late arrival forces tail-chain
    step(1, 14, 10, 1, 0, "R7");      // 10 not below 8: return
    step(0, 0, 0, 1, 0, "R7");        // return to empty
    step(0, 0, 0, 1, 0, "R8");        // done on empty ignored
    step(0, 0, 0, 1, 1, "R8");
    step(1, 15, 6, 1, 0, "R8");       // done ignored, entry still taken
    step(0, 0, 0, 1, 0, "R7");

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 2) == 0, int'($urandom % 32), int'($urandom % 16),
           ($urandom % 3) == 0, ($urandom % 5) == 0, "R9");
    end
    while (m_prio.size() > 0) step(0, 0, 0, 1, 0, "R7");

    for (int i = 0; i < SD; i++) step(1, i + 1, 14 - i, 0, 0, "R3");
    step(1, 20, 1, 0, 0, "R10");      // push on full refused
    step(0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < SD; i++) step(0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, "R10");       // overflow flag stays set

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule